// File: doc/BRIEF.md
# Sequential Horner Polynomial Evaluator

This block evaluates a polynomial of fixed degree, with signed coefficients, at a signed input value. The coefficients are build-time parameters held in an internal table. A one-cycle start pulse latches the input value and loads the accumulator with the leading coefficient. After that, each clock cycle performs one nested step: the accumulator is multiplied by the latched input and the next lower coefficient is added. One multiplier and one adder are reused for every step, so the datapath stays the same size for any degree.

Every product is cut back to the data width by keeping its low half. The design assumes that intermediate values fit in that width. Results that do not fit wrap in two's complement, and nothing reports the overflow. A done flag marks the result as valid and stays high until the next evaluation is accepted. While done is low, the result port has no meaning.

Top module: `horner_eval`

## Requirements
- R1: While reset (active high, asynchronous) is asserted and after it is released, done is 0 and the result port is 0 until a start is accepted.
- R2: For the default table, the result equals 3x³ − 2x² − 4x + 5 evaluated in the nested form (((3)·x − 2)·x − 4)·x + 5.
- R3: When a start is accepted at clock edge E, done rises at edge E+DEGREE (E+3 by default) and is 0 at every edge between them.
- R4: While done is 1 and start is 0, done stays 1 and the result port keeps its value, whatever the data input does.
- R5: A start sampled while done is 1 is accepted: done is 0 after that edge and a new evaluation begins.
- R6: The data input is latched at the accepting edge; changing it during the evaluation does not change the result.
- R7: A start sampled while an evaluation is in progress is ignored: the result and the done timing are those of the first start.
- R8: Each product keeps only its low WIDTH bits, so results wrap modulo 2^WIDTH (two's complement).
- R9: Table index k holds the coefficient of x^k. The default is index 0 = 5, 1 = −4, 2 = −2, 3 = 3. At x = 0 the result is 5, at x = 1 it is 2, and at x = −1 it is 4.
- R10: Asserting reset during an evaluation aborts it. done stays 0 after release until a new start has been accepted and has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | One-cycle request to evaluate at x_in |
| x_in | input | WIDTH | Signed input value |
| y_out | output | WIDTH | Signed result, valid while done is 1 |
| done | output | 1 | Result valid flag |

## Verification
A wrong coefficient index or a bad step counter shows up as a wrong y_out or a misplaced done on the very first evaluation. The sweep of small inputs separates every coefficient term, because each power of x contributes a distinct amount. A controller that restarts on a start arriving mid-evaluation, or that forgets the latched input, shows within DEGREE cycles as done coming late or as the result for the wrong input. An abort on reset that is not clean shows as a stray done within a few cycles after release.

// File: rtl/horner_pkg.sv
package horner_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/horner_coef_rom.sv
module horner_coef_rom #(
    parameter int WIDTH  = 32,
    parameter int DEGREE = 3,
    parameter int COEF [0:DEGREE] = '{5, -4, -2, 3},
    localparam int CW = $clog2(DEGREE + 1)
) (
    input  logic [CW-1:0]           idx,
    output logic signed [WIDTH-1:0] coef
);
    logic signed [WIDTH-1:0] tbl [0:DEGREE];

    for (genvar k = 0; k <= DEGREE; k++) begin : g_tbl
        assign tbl[k] = WIDTH'(COEF[k]);
    end

    always_comb begin
        if (int'(idx) > DEGREE) coef = '0;
        else                    coef = tbl[idx];
    end
endmodule

// File: rtl/horner_ctrl.sv
module horner_ctrl
    import horner_pkg::*;
#(
    parameter int DEGREE = 3,
    localparam int CW = $clog2(DEGREE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic [CW-1:0] idx,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = start && (st_q.phase != PH_RUN);
        step = (st_q.phase == PH_RUN);
        idx  = load ? CW'(DEGREE) : CW'(st_q.cnt - 1'b1);
        if (load) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = CW'(DEGREE);
        end else if (step) begin
            st_d.cnt = CW'(st_q.cnt - 1'b1);
            if (st_q.cnt == CW'(1)) st_d.phase = PH_DONE;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = (st_q.phase == PH_DONE);

    // R3 / R7: the step count only goes down while running; a start does not reload it
    p_run_count_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RUN && st_q.cnt > CW'(1)) |=>
        (st_q.phase == PH_RUN && st_q.cnt == CW'($past(st_q.cnt) - 1'b1)));

    p_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RUN && st_q.cnt == CW'(1)) |=> (st_q.phase == PH_DONE));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RUN && start) |=> (st_q.cnt != CW'(DEGREE) || DEGREE == 1));
endmodule

// File: rtl/horner_mac.sv
module horner_mac #(
    parameter int WIDTH = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    step,
    input  logic signed [WIDTH-1:0] x_in,
    input  logic signed [WIDTH-1:0] coef,
    output logic signed [WIDTH-1:0] acc
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic signed [WIDTH-1:0] x;
        logic signed [WIDTH-1:0] acc;
    } mac_t;

    mac_t st_d, st_q;
    logic signed [PW-1:0] prod;

    always_comb begin
        st_d = st_q;
        prod = st_q.acc * st_q.x;
        if (load) begin
            st_d.x   = x_in;
            st_d.acc = coef;
        end else if (step) begin
            st_d.acc = prod[WIDTH-1:0] + coef;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc = st_q.acc;

    // R3: the controller never asks for a load and a step together
    p_one_op_r3: assert property (@(posedge clk) disable iff (rst) !(load && step));

    // R6: the latched operand holds across every step
    p_x_held_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(st_q.x));
endmodule

// File: rtl/horner_eval.sv
module horner_eval #(
    parameter int WIDTH  = 32,
    parameter int DEGREE = 3,
    parameter int COEF [0:DEGREE] = '{5, -4, -2, 3},
    localparam int CW = $clog2(DEGREE + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [WIDTH-1:0] x_in,
    output logic signed [WIDTH-1:0] y_out,
    output logic                    done
);
    logic                    load, step;
    logic [CW-1:0]           idx;
    logic signed [WIDTH-1:0] coef;

    horner_ctrl #(.DEGREE(DEGREE)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .idx(idx), .done(done)
    );

    horner_coef_rom #(.WIDTH(WIDTH), .DEGREE(DEGREE), .COEF(COEF)) u_rom (
        .idx(idx), .coef(coef)
    );

    horner_mac #(.WIDTH(WIDTH)) u_mac (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .x_in(x_in), .coef(coef), .acc(y_out)
    );

    // R4: a finished result holds until a start arrives
    p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(y_out)));

    // R5: a start on a finished result opens a new evaluation
    p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);
endmodule

// File: tb/sim_horner_eval.sv
module sim_horner_eval;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 32;
    localparam int DEG = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [W-1:0] x_in = '0;
    logic signed [W-1:0] y_out;
    logic done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    horner_eval u0 (
        .clk(clk), .rst(rst), .start(start),
        .x_in(x_in), .y_out(y_out), .done(done)
    );

    function automatic logic signed [W-1:0] f_ref(input logic signed [W-1:0] v);
        logic signed [W-1:0] r;
        r = 3 * v * v * v - 2 * v * v - 4 * v + 5;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic signed [W-1:0] v);
        @(negedge clk);
        start = 1'b1;
        x_in  = v;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5 done low after accepted start", done, 0);
    endtask

    task automatic await_result(input logic signed [W-1:0] exp, input string req);
        for (int i = 1; i < DEG; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R3 done early", done, 0);
        end
        @(negedge clk);
        check(done == 1'b1, "R3 done at latency", done, 1);
        check(y_out == exp, req, y_out, exp);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(y_out == 0, "R1 result in reset", y_out, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done after release", done, 0);
        check(y_out == 0, "R1 result after release", y_out, 0);
    endtask

    task automatic t_coef_order;
        launch(0);  await_result(5, "R9 x=0");
        launch(1);  await_result(2, "R9 x=1");
        launch(-1); await_result(4, "R9 x=-1");
    endtask

    task automatic t_known;
        launch(4);  await_result(f_ref(4),  "R2 x=4");
        launch(7);  await_result(f_ref(7),  "R2 x=7");
        launch(15); await_result(f_ref(15), "R2 x=15");
        launch(-9); await_result(f_ref(-9), "R2 x=-9");
    endtask

    task automatic t_sweep;
        for (int v = -20; v <= 20; v++) begin
            launch(W'(v));
            await_result(f_ref(W'(v)), "R2 sweep");
        end
    endtask

    task automatic t_wrap;
        launch(2000);    await_result(f_ref(2000),    "R8 wrap x=2000");
        launch(100000);  await_result(f_ref(100000),  "R8 wrap x=100000");
        launch(-77777);  await_result(f_ref(-77777),  "R8 wrap x=-77777");
    endtask

    task automatic t_hold;
        logic signed [W-1:0] exp;
        exp = f_ref(11);
        launch(11);
        await_result(exp, "R4 base");
        for (int i = 0; i < 6; i++) begin
            x_in = W'(i * 1234 - 999);
            @(negedge clk);
            check(done == 1'b1, "R4 done holds", done, 1);
            check(y_out == exp, "R4 result holds", y_out, exp);
        end
    endtask

    task automatic t_restart;
        launch(-3);
        await_result(f_ref(-3), "R5 first");
        launch(8);
        await_result(f_ref(8), "R5 second");
    endtask

    task automatic t_x_change;
        launch(3);
        x_in = 50;
        await_result(f_ref(3), "R6 input change ignored");
    endtask

    task automatic t_busy_start;
        launch(5);
        @(negedge clk);
        start = 1'b1;
        x_in  = 9;
        check(done == 1'b0, "R7 done low mid-run", done, 0);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 done low mid-run", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R7 done on first timing", done, 1);
        check(y_out == f_ref(5), "R7 result of first start", y_out, f_ref(5));
        @(negedge clk);
        check(done == 1'b1, "R7 no restart", done, 1);
        check(y_out == f_ref(5), "R7 result kept", y_out, f_ref(5));
    endtask

    task automatic t_reset_mid;
        launch(6);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check(done == 1'b0, "R10 done in reset", done, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R10 no stray done", done, 0);
        end
        launch(2);
        await_result(f_ref(2), "R10 after abort");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_coef_order();
        t_known();
        t_sweep();
        t_wrap();
        t_hold();
        t_restart();
        t_x_change();
        t_busy_start();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule